// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block is a real-time clock counter. It keeps seconds, minutes, hours, day of month, month and a two-digit year (00 to 99, meaning 2000 to 2099), each held as one packed-BCD byte. It runs in 24-hour form only. Time advances once every `TICKS_PER_SEC` pulses of a slow tick enable (32768 per second by default). It offers a byte-wide register port for reading and loading the time, for starting and stopping the count, and for reading and clearing event status.

A busy flag covers the final tick period before each one-second update. Time loads are refused while it is high, so software that waits for busy to fall gets a safe window of almost a full second. The status byte mixes live state (busy, running) with sticky event flags. The event flags are the second, minute, hour and day rollovers, an alarm input driven by a separate match block, and a power-on marker. All sticky flags are cleared by writing one to them. A single interrupt line follows the one-second flag when the periodic interrupt is enabled.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 0x00, day and month read 0x01, control reads 0x00, status reads 0x80, the interrupt-enable register reads 0x00 and `irq_o` is low.
- R2: Control register 0x40 bit 0 set to 1 runs the clock. With it at 0 the time registers hold and status bits 0 (busy) and 1 (running) both read 0. Status bit 1 reads the value of control bit 0. Control bits 7..1 read 0.
- R3: While running, seconds advance by one every `TICKS_PER_SEC` ticks. Status bit 0 (busy) is high for exactly the final tick period before each advance.
- R4: Seconds 0x59 wrap to 0x00 and advance minutes. Minutes 0x59 wrap to 0x00 and advance hours. Hours 0x23 wrap to 0x00 and advance the day. Hours between 0x12 and 0x23 count on in 24-hour form.
- R5: The last day is 0x30 for months 0x04, 0x06, 0x09 and 0x11, 0x31 for the other months except 0x02, and for 0x02 it is 0x29 when the year is divisible by 4 and 0x28 otherwise. After the last day the day goes to 0x01 and the month advances.
- R6: Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00.
- R7: Time registers sit at 0x00 (seconds), 0x04 (minutes), 0x08 (hours), 0x0C (day), 0x10 (month) and 0x14 (year). A write loads the byte unchanged when busy is low and is ignored when busy is high.
- R8: Status bits 2, 3, 4 and 5 are set on each second, minute, hour and day advance respectively and stay set until cleared.
- R9: Writing 1 to any of status bits 7..2 clears that bit. A 0 written leaves it unchanged.
- R10: A one-cycle pulse on `alarm_i` sets status bit 6.
- R11: Status bit 7 is set by reset and stays set until software writes 1 to it.
- R12: Register 0x48 bit 2 enables the periodic interrupt. `irq_o` is high exactly while that enable and status bit 2 are both 1.
- R13: A read of any address not listed in R2, R7 or R12 and other than the status address 0x44 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable per oscillator period |
| alarm_i | input | 1 | Alarm match pulse from the alarm block |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Periodic interrupt request |

## Verification
The calendar is driven through every year 00 to 99 at the end of February, so leap and non-leap years are each seen to produce day 0x29 or March. It is also driven through the last day of all twelve months and the last day minus one, which separates month-length errors from carry errors. The year wrap is tried from 99-12-31. A free run of more than a minute checks each second against a counter in the bench. Busy timing is measured cycle by cycle between two updates, and loads are attempted both inside and just after busy so that an accepted write and a refused write are told apart.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 8;
  localparam int BCD_W       = 8;
  localparam int NUM_FIELDS  = 6;
  localparam int FIELD_IDX_W = 3;
  localparam int NUM_EVT     = 6;  // status bits 7..2

  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HOUR = 2;
  localparam int FLD_DAY  = 3;
  localparam int FLD_MON  = 4;
  localparam int FLD_YEAR = 5;

  localparam logic [ADDR_W-1:0] ADDR_TIME_LAST = 8'h14;
  localparam logic [ADDR_W-1:0] ADDR_CTRL      = 8'h40;
  localparam logic [ADDR_W-1:0] ADDR_STATUS    = 8'h44;
  localparam logic [ADDR_W-1:0] ADDR_IRQ       = 8'h48;

  localparam int CTRL_RUN_BIT = 0;
  localparam int IRQ_TMR_BIT  = 2;

  // packed [field][bcd], field 0 = seconds
  localparam logic [NUM_FIELDS-1:0][BCD_W-1:0] FIELD_RST   = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  localparam logic [NUM_FIELDS-1:0][BCD_W-1:0] FIELD_FIRST = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  localparam logic [NUM_FIELDS-1:0][BCD_W-1:0] FIELD_LAST  = {8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59};

  localparam logic [NUM_EVT-1:0] EVT_RST = 6'b100000;  // power-up flag only

  function automatic logic [BCD_W-1:0] bcd_inc(input logic [BCD_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10t+o mod 4 == 2t+o mod 4
  function automatic logic bcd_leap(input logic [BCD_W-1:0] yr);
    logic [1:0] s;
    s = yr[1:0] + {yr[4], 1'b0};
    return s == 2'd0;
  endfunction

  function automatic logic [BCD_W-1:0] bcd_last_day(input logic [BCD_W-1:0] mon,
                                                     input logic [BCD_W-1:0] yr);
    case (mon)
      8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic busy_o,
  output logic sec_pulse_o
);
  localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign busy_o      = run_i && (cnt_q == CNT_LAST);
  assign sec_pulse_o = busy_o && tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
  end

  a_r3_busy_one_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tick_i) |=> !busy_o);
  a_r2_stopped_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field import rtc_pkg::*; #(
  parameter logic [BCD_W-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic [BCD_W-1:0] wdata_i,
  input  logic [BCD_W-1:0] first_i,
  input  logic [BCD_W-1:0] last_i,
  output logic [BCD_W-1:0] val_o,
  output logic             wrap_o
);
  logic [BCD_W-1:0] val_q;

  assign val_o  = val_q;
  assign wrap_o = inc_i && (val_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= RST_VAL;
    else if (wr_i)   val_q <= wdata_i;
    else if (inc_i)  val_q <= wrap_o ? first_i : bcd_inc(val_q);
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar import rtc_pkg::*; (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 sec_pulse_i,
  input  logic                                 wr_en_i,
  input  logic [FIELD_IDX_W-1:0]               wr_idx_i,
  input  logic [BCD_W-1:0]                     wr_data_i,
  output logic [NUM_FIELDS-1:0][BCD_W-1:0]     time_o,
  output logic [3:0]                           roll_o
);
  logic [NUM_FIELDS-1:0]             inc;
  logic [NUM_FIELDS-1:0]             wrap;
  logic [NUM_FIELDS-1:0][BCD_W-1:0]  val;
  logic [NUM_FIELDS-1:0][BCD_W-1:0]  last_v;

  always_comb begin
    last_v          = FIELD_LAST;
    last_v[FLD_DAY] = bcd_last_day(val[FLD_MON], val[FLD_YEAR]);
  end

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_fld
    if (gi == 0) begin : g_head
      assign inc[gi] = sec_pulse_i;
    end else begin : g_carry
      assign inc[gi] = wrap[gi-1];
    end

    rtc_bcd_field #(.RST_VAL(FIELD_RST[gi])) u_field (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (inc[gi]),
      .wr_i    (wr_en_i && (wr_idx_i == FIELD_IDX_W'(gi))),
      .wdata_i (wr_data_i),
      .first_i (FIELD_FIRST[gi]),
      .last_i  (last_v[gi]),
      .val_o   (val[gi]),
      .wrap_o  (wrap[gi])
    );
  end

  assign time_o = val;
  assign roll_o = inc[3:0];

  a_r4_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse_i && val[FLD_SEC] == 8'h59) |=> (val[FLD_SEC] == 8'h00));
  a_r4_hour_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc[FLD_HOUR] && val[FLD_HOUR] == 8'h23) |=> (val[FLD_HOUR] == 8'h00));
  a_r5_day_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap[FLD_DAY] |=> (val[FLD_DAY] == 8'h01));
  a_r6_year_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap[FLD_YEAR] && !wr_en_i) |=> (val[FLD_YEAR] == 8'h00 && val[FLD_MON] == 8'h01));
endmodule

// File: rtl/rtc_status.sv
module rtc_status #(
  parameter int                 NUM_EVT = 6,
  parameter logic [NUM_EVT-1:0] RST_VAL = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] evt_o
);
  logic [NUM_EVT-1:0] evt_q;

  for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) evt_q[gi] <= RST_VAL[gi];
      else         evt_q[gi] <= set_i[gi] | (evt_q[gi] & ~clr_i[gi]);
    end
  end

  assign evt_o = evt_q;

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_q) |=> (($past(evt_q) & ~$past(clr_i) & ~evt_q) == '0));
  a_r8_set_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((evt_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core import rtc_pkg::*; #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              alarm_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic                             run_q;
  logic                             irq_en_q;
  logic                             busy;
  logic                             sec_pulse;
  logic                             time_hit;
  logic [FIELD_IDX_W-1:0]           time_idx;
  logic [NUM_FIELDS-1:0][BCD_W-1:0] time_w;
  logic [3:0]                       roll;
  logic [NUM_EVT-1:0]               evt;
  logic [NUM_EVT-1:0]               evt_set;
  logic [NUM_EVT-1:0]               evt_clr;
  logic                             irq_wr;

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_q),
    .tick_i      (tick_i),
    .busy_o      (busy),
    .sec_pulse_o (sec_pulse)
  );

  assign time_hit = (addr_i <= ADDR_TIME_LAST) && (addr_i[1:0] == 2'b00);
  assign time_idx = addr_i[FIELD_IDX_W+1:2];

  rtc_calendar u_cal (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sec_pulse_i (sec_pulse),
    .wr_en_i     (we_i && time_hit && !busy),
    .wr_idx_i    (time_idx),
    .wr_data_i   (wdata_i),
    .time_o      (time_w),
    .roll_o      (roll)
  );

  // status bits 7..2: power-up, alarm, day, hour, minute, second
  assign evt_set = {1'b0, alarm_i, roll};
  assign evt_clr = (we_i && addr_i == ADDR_STATUS) ? wdata_i[DATA_W-1:2] : '0;

  rtc_status #(.NUM_EVT(NUM_EVT), .RST_VAL(EVT_RST)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_set),
    .clr_i  (evt_clr),
    .evt_o  (evt)
  );

  assign irq_wr = we_i && (addr_i == ADDR_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (we_i && addr_i == ADDR_CTRL) run_q <= wdata_i[CTRL_RUN_BIT];
      if (irq_wr)                      irq_en_q <= wdata_i[IRQ_TMR_BIT];
    end
  end

  assign irq_o = irq_en_q && evt[0];

  always_comb begin
    rdata_o = '0;
    if (time_hit) begin
      rdata_o = time_w[time_idx];
    end else begin
      case (addr_i)
        ADDR_CTRL:   rdata_o[CTRL_RUN_BIT] = run_q;
        ADDR_STATUS: rdata_o = {evt, run_q, busy};
        ADDR_IRQ:    rdata_o[IRQ_TMR_BIT] = irq_en_q;
        default:     rdata_o = '0;
      endcase
    end
  end

  a_r7_busy_blocks_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && we_i && time_hit && !tick_i) |=> $stable(time_w));
  a_r12_irq_on_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse && irq_en_q && !irq_wr) |=> irq_o);
  a_r2_stopped_time_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !we_i) |=> $stable(time_w));
endmodule

// File: tb/rtc_bcd_core_bench.sv
module rtc_bcd_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 4;
  localparam int TICK_DIV   = 2;
  localparam int SEC_CYC    = TPS * TICK_DIV;

  localparam logic [7:0] A_SEC = 8'h00, A_MIN = 8'h04, A_HOUR = 8'h08;
  localparam logic [7:0] A_DAY = 8'h0C, A_MON = 8'h10, A_YEAR = 8'h14;
  localparam logic [7:0] A_CTRL = 8'h40, A_STAT = 8'h44, A_IRQ = 8'h48;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       alarm = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int tdiv   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) tdiv <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
  assign tick = (tdiv == TICK_DIV-1);

  rtc_bcd_core #(.TICKS_PER_SEC(TPS)) u_rtc_bcd_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .alarm_i(alarm),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) % 10) * 16 + (v % 10));
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic load_time(input int y, input int mo, input int d,
                           input int h, input int mi, input int s);
    wr(A_CTRL, 8'h00);
    wr(A_YEAR, bcd(y)); wr(A_MON, bcd(mo)); wr(A_DAY, bcd(d));
    wr(A_HOUR, bcd(h)); wr(A_MIN, bcd(mi)); wr(A_SEC, bcd(s));
  endtask

  task automatic check_time(input string tag, input int y, input int mo, input int d,
                            input int h, input int mi, input int s);
    logic [7:0] v;
    rd(A_YEAR, v); check({tag, " year"}, v, bcd(y));
    rd(A_MON, v);  check({tag, " month"}, v, bcd(mo));
    rd(A_DAY, v);  check({tag, " day"}, v, bcd(d));
    rd(A_HOUR, v); check({tag, " hour"}, v, bcd(h));
    rd(A_MIN, v);  check({tag, " min"}, v, bcd(mi));
    rd(A_SEC, v);  check({tag, " sec"}, v, bcd(s));
  endtask

  task automatic wait_change(output int cyc);
    logic [7:0] s0, s;
    rd(A_SEC, s0);
    cyc = 0;
    do begin
      @(negedge clk);
      rd(A_SEC, s);
      cyc++;
    end while (s == s0 && cyc < 64);
    if (cyc >= 64) check("R3 second advance timeout", 0, 1);
  endtask

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v, s0;
    int cyc, nb, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_time("R1 reset", 0, 1, 1, 0, 0, 0);
    rd(A_CTRL, v); check("R1 ctrl", v, 8'h00);
    rd(A_STAT, v); check("R1 status", v, 8'h80);
    rd(A_IRQ, v);  check("R1 irq enable", v, 8'h00);
    check("R1 irq line", irq, 0);

    // R11 power-up flag
    wr(A_STAT, 8'h00); rd(A_STAT, v); check("R11 zero write keeps power-up", v, 8'h80);
    wr(A_STAT, 8'h80); rd(A_STAT, v); check("R11 power-up cleared", v, 8'h00);

    // R13 unmapped reads, R2 ctrl readback
    rd(8'h60, v); check("R13 unmapped 0x60", v, 8'h00);
    rd(8'h02, v); check("R13 unaligned 0x02", v, 8'h00);
    rd(8'h18, v); check("R13 past year 0x18", v, 8'h00);
    wr(A_CTRL, 8'hFF); rd(A_CTRL, v); check("R2 ctrl readback", v, 8'h01);
    rd(A_STAT, v); check("R2 run bit in status", v & 8'h02, 8'h02);

    // R2 stopped holds
    load_time(24, 1, 1, 0, 0, 10);
    nb = 0;
    for (int i = 0; i < 5 * SEC_CYC; i++) begin
      @(negedge clk); rd(A_STAT, v);
      if (v[1:0] != 2'b00) nb++;
    end
    check("R2 stopped busy/run low", nb, 0);
    check_time("R2 stopped hold", 24, 1, 1, 0, 0, 10);

    // R3 period and busy width, R4 free-run sweep
    load_time(24, 1, 1, 0, 0, 0);
    wr(A_CTRL, 8'h01);
    wait_change(cyc);
    wait_change(cyc);
    check("R3 second period", cyc, SEC_CYC);
    nb = 0;
    for (int i = 0; i < SEC_CYC; i++) begin
      @(negedge clk); rd(A_STAT, v);
      if (v[0]) nb++;
    end
    check("R3 busy cycles per second", nb, TICK_DIV);
    rd(A_SEC, v); n = (v[7:4] * 10 + v[3:0]);
    for (int k = 0; k < 70; k++) begin
      wait_change(cyc);
      n++;
      rd(A_SEC, v); check("R4 free-run sec", v, bcd(n % 60));
      rd(A_MIN, v); check("R4 free-run min", v, bcd(n / 60));
    end

    // R7 load blocked by busy, accepted after
    load_time(24, 1, 1, 0, 0, 0);
    wr(A_CTRL, 8'h01);
    n = 0;
    do begin @(negedge clk); rd(A_STAT, v); n++; end while (!v[0] && n < 64);
    rd(A_SEC, s0);
    wr(A_SEC, 8'h30);
    n = 0;
    do begin rd(A_STAT, v); if (v[0]) @(negedge clk); n++; end while (v[0] && n < 64);
    rd(A_SEC, v); check("R7 load ignored while busy", v, bcd((s0[7:4] * 10 + s0[3:0]) + 1));
    wr(A_SEC, 8'h45);
    rd(A_SEC, v); check("R7 load accepted when idle", v, 8'h45);
    wr(A_MON, 8'h07); rd(A_MON, v); check("R7 month load", v, 8'h07);

    // R4 24-hour count
    load_time(24, 1, 1, 12, 59, 59);
    wr(A_CTRL, 8'h01); wait_change(cyc); wr(A_CTRL, 8'h00);
    check_time("R4 noon carry", 24, 1, 1, 13, 0, 0);

    // R5 leap sweep over all years
    for (int y = 0; y < 100; y++) begin
      load_time(y, 2, 28, 23, 59, 59);
      wr(A_CTRL, 8'h01); wait_change(cyc); wr(A_CTRL, 8'h00);
      if (y % 4 == 0) check_time("R5 feb28 leap", y, 2, 29, 0, 0, 0);
      else            check_time("R5 feb28 common", y, 3, 1, 0, 0, 0);
      if (y % 4 == 0) begin
        load_time(y, 2, 29, 23, 59, 59);
        wr(A_CTRL, 8'h01); wait_change(cyc); wr(A_CTRL, 8'h00);
        check_time("R5 feb29 leap", y, 3, 1, 0, 0, 0);
      end
    end

    // R5 month lengths, R6 december
    for (int m = 1; m <= 12; m++) begin
      load_time(23, m, mdays(m, 23) - 1, 23, 59, 59);
      wr(A_CTRL, 8'h01); wait_change(cyc); wr(A_CTRL, 8'h00);
      check_time("R5 day before last", 23, m, mdays(m, 23), 0, 0, 0);
      load_time(23, m, mdays(m, 23), 23, 59, 59);
      wr(A_CTRL, 8'h01); wait_change(cyc); wr(A_CTRL, 8'h00);
      if (m == 12) check_time("R6 year advance", 24, 1, 1, 0, 0, 0);
      else         check_time("R5 month advance", 23, m + 1, 1, 0, 0, 0);
    end
    load_time(99, 12, 31, 23, 59, 59);
    wr(A_CTRL, 8'h01); wait_change(cyc); wr(A_CTRL, 8'h00);
    check_time("R6 year 99 wrap", 0, 1, 1, 0, 0, 0);

    // R8 events on full rollover, R9 clear
    load_time(23, 12, 31, 23, 59, 59);
    wr(A_STAT, 8'hFC);
    wr(A_CTRL, 8'h01); wait_change(cyc); wr(A_CTRL, 8'h00);
    rd(A_STAT, v); check("R8 all rollover events", v, 8'h3C);
    wr(A_STAT, 8'h04); rd(A_STAT, v); check("R9 clear second only", v, 8'h38);
    wr(A_STAT, 8'h00); rd(A_STAT, v); check("R9 zero write no effect", v, 8'h38);

    // R10 alarm input
    alarm = 1'b1; @(negedge clk); alarm = 1'b0;
    rd(A_STAT, v); check("R10 alarm flag", v, 8'h78);
    wr(A_STAT, 8'h40); rd(A_STAT, v); check("R9 alarm clear", v, 8'h38);
    wr(A_STAT, 8'h38); rd(A_STAT, v); check("R9 clear rest", v, 8'h00);

    // R8 plain second sets only bit 2
    load_time(23, 5, 5, 5, 5, 10);
    wr(A_CTRL, 8'h01); wait_change(cyc); wr(A_CTRL, 8'h00);
    rd(A_STAT, v); check("R8 second event only", v, 8'h04);

    // R12 interrupt
    check("R12 irq low while disabled", irq, 0);
    wr(A_IRQ, 8'h04); rd(A_IRQ, v); check("R12 enable readback", v, 8'h04);
    check("R12 irq high", irq, 1);
    wr(A_STAT, 8'h04); check("R12 irq drops on clear", irq, 0);
    wr(A_IRQ, 8'h00);
    wr(A_CTRL, 8'h01); wait_change(cyc); wr(A_CTRL, 8'h00);
    check("R12 irq masked", irq, 0);
    wr(A_IRQ, 8'hFB); rd(A_IRQ, v); check("R12 other bits ignored", v, 8'h00);
    wr(A_IRQ, 8'h04); check("R12 irq after enable", irq, 1);
    repeat (3 * SEC_CYC) @(negedge clk);
    #1; check("R12 irq held until clear", irq, 1);

    finish_run();
  end
endmodule